// File: doc/BRIEF.md
# SPI master shift engine

This block moves one byte between the chip and an attached SPI slave per transfer. It drives the serial clock, the outgoing data line and an automatic active-low slave select, and it captures the incoming data line. A host writes a byte to the data location to start a transfer. When the exchange is over, the same location returns the byte collected from the slave. A status location reports completion and write collisions and holds an interrupt-enable bit. The completion flag combined with that bit drives an interrupt request.

Clock polarity, clock phase, bit order and a three-bit rate select are static inputs. They may be changed only while no transfer is in flight. One SCK half-period lasts 2^(rate+1) system clocks. The same half-period sets three guard intervals: the time from select falling to the first SCK edge, the time from the last edge to select rising, and the minimum time select stays high before the block accepts another transfer.

Top module: `spi_xfer_master`

## Requirements
- R1: A write to the data location (host_sel=1) while the block is idle loads the byte and drives ss_n low at the next clock edge. The first SCK edge follows exactly one half-period H after that.
- R2: Every transfer makes exactly 16 SCK edges, spaced H clocks apart. Whenever ss_n is high, SCK rests at the level of cpol (0 when cpol=0, 1 when cpol=1).
- R3: With cpha=0, the first data bit is on mosi as soon as ss_n falls, and mosi changes on the even-numbered edges. With cpha=1, mosi changes on odd-numbered edges from edge 3 onward. With lsb_first=0 bits go out from bit 7 down to bit 0; with lsb_first=1 they go out from bit 0 up to bit 7.
- R4: miso is sampled on odd edges when cpha=0 and on even edges when cpha=1. Received bits are assembled in the same order as the transmitted bits. After completion, a data-location read returns the slave's byte.
- R5: ss_n stays low for H clocks after the 16th edge.
- R6: After ss_n rises, the block stays busy for a further H clocks and then sets the completion flag (status bit 7). This happens 18·H clocks after the accepting edge.
- R7: H equals 2^(baud+1) system clocks for baud values 0 to 7.
- R8: irq is high exactly when the completion flag and the interrupt-enable bit (status bit 0, written through wdata bit 0 at host_sel=0) are both set.
- R9: The completion flag and the collision flag clear only when a status read made while either flag was set is followed by a data-location read or write. A data access without that prior status read leaves both flags set.
- R10: A data-location write while busy is ignored: the ongoing transfer and its outgoing bits are unchanged. It sets the collision flag (status bit 6).
- R11: After reset, ss_n is high, SCK sits at cpol, irq is low and the status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | 1 = least significant bit first |
| baud | input | 3 | Half-period select, H = 2^(baud+1) |
| host_sel | input | 1 | 0 = status location, 1 = data location |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected location |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Automatic active-low slave select |

## Verification
The hardest case to reach is a data write that lands in the middle of a live transfer. That write must leave the outgoing bit stream untouched while it raises the collision flag. The bench issues such a write several half-periods into a transfer. The reference model keeps comparing mosi against the original byte, and the status is read back before and after the clear sequence. A second awkward case is a data access that arrives without the preceding status read. The bench performs one and then confirms that both flags are still set.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_GAP
  } xfer_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);
  localparam int CNT_W = 1 << BAUD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [CNT_W:0]   span;
  logic [BAUD_W:0]  shamt;

  always_comb begin
    shamt = {1'b0, baud} + 1'b1;
    span  = (CNT_W+1)'(1) << shamt;
    lim   = CNT_W'(span - 1'b1);
    tick  = run && (cnt_q == lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic edge_ev,
  output logic edge_odd,
  output logic edge_first,
  output logic edge_last,
  output logic sck_lvl,
  output logic ss_n,
  output logic busy,
  output logic done_set
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES);

  xfer_state_e     state_q, state_d;
  logic [EC_W-1:0] ecnt_q, ecnt_d;
  logic            sck_q, sck_d;

  always_comb begin
    edge_ev    = tick && (state_q == ST_LEAD || state_q == ST_XFER);
    edge_odd   = ~ecnt_q[0];
    edge_first = (ecnt_q == '0);
    edge_last  = (ecnt_q == EC_W'(EDGES - 1));
    done_set   = tick && (state_q == ST_GAP);
    state_d    = state_q;
    ecnt_d     = ecnt_q;
    sck_d      = sck_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_LEAD;
      ST_LEAD, ST_XFER: begin
        if (tick) begin
          sck_d   = ~sck_q;
          ecnt_d  = edge_last ? '0 : ecnt_q + 1'b1;
          state_d = edge_last ? ST_TRAIL : ST_XFER;
        end
      end
      ST_TRAIL: if (tick) state_d = ST_GAP;
      ST_GAP:   if (tick) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      sck_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      sck_q   <= sck_d;
    end
  end

  assign sck_lvl = sck_q;
  assign ss_n    = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign busy    = (state_q != ST_IDLE);

  assert_lead_guard_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q != $past(sck_q)) |-> (!ss_n && !$past(ss_n)));
  assert_sck_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sck_q);
  assert_trail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> ($past(tick) && !$past(edge_ev)));
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              edge_ev,
  input  logic              edge_odd,
  input  logic              edge_first,
  input  logic              edge_last,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              miso,
  output logic [DATA_W-1:0] shreg,
  output logic              mosi
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              rx_q, rx_d;
  logic              sample_en, shift_en, shift_in;

  always_comb begin
    sample_en = edge_ev && (cpha ? !edge_odd && !edge_last : edge_odd);
    shift_en  = edge_ev && (cpha ? ((edge_odd && !edge_first) || edge_last)
                                 : !edge_odd);
    shift_in  = (cpha && edge_last) ? miso : rx_q;
    rx_d      = sample_en ? miso : rx_q;
    sr_d      = sr_q;
    if (load)
      sr_d = load_data;
    else if (shift_en)
      sr_d = lsb_first ? {shift_in, sr_q[DATA_W-1:1]}
                       : {sr_q[DATA_W-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      rx_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      rx_q <= rx_d;
    end
  end

  assign shreg = sr_q;
  assign mosi  = lsb_first ? sr_q[0] : sr_q[DATA_W-1];

  assert_no_shift_and_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_en && shift_en && !(cpha && edge_last)));
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int DATA_W = 8,
  parameter int BAUD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [BAUD_W-1:0] baud,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  logic tick, busy, start, coll, data_acc, clr;
  logic edge_ev, edge_odd, edge_first, edge_last, sck_lvl, done_set;
  logic [DATA_W-1:0] shreg;
  logic done_q, done_d, wcol_q, wcol_d, ie_q, ie_d, arm_q, arm_d;

  spi_half_timer #(.BAUD_W(BAUD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .baud(baud), .tick(tick)
  );

  spi_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .edge_ev(edge_ev), .edge_odd(edge_odd), .edge_first(edge_first),
    .edge_last(edge_last), .sck_lvl(sck_lvl), .ss_n(ss_n),
    .busy(busy), .done_set(done_set)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(host_wdata),
    .edge_ev(edge_ev), .edge_odd(edge_odd), .edge_first(edge_first),
    .edge_last(edge_last), .cpha(cpha), .lsb_first(lsb_first),
    .miso(miso), .shreg(shreg), .mosi(mosi)
  );

  always_comb begin
    data_acc = host_sel && (host_wr || host_rd);
    start    = host_sel && host_wr && !busy;
    coll     = host_sel && host_wr && busy;
    clr      = data_acc && arm_q;
    done_d   = done_set ? 1'b1 : (clr ? 1'b0 : done_q);
    wcol_d   = coll ? 1'b1 : (clr ? 1'b0 : wcol_q);
    ie_d     = (host_wr && !host_sel) ? host_wdata[0] : ie_q;
    if (clr)
      arm_d = 1'b0;
    else if (host_rd && !host_sel && (done_q || wcol_q))
      arm_d = 1'b1;
    else
      arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      ie_q   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      wcol_q <= wcol_d;
      ie_q   <= ie_d;
      arm_q  <= arm_d;
    end
  end

  assign host_rdata = host_sel ? shreg
                               : {done_q, wcol_q, {(DATA_W-3){1'b0}}, ie_q};
  assign irq = done_q && ie_q;
  assign sck = sck_lvl ^ cpol;

  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && busy) |=> wcol_q);
  assert_flag_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (ss_n && $past(ss_n)));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(arm_q && data_acc));
endmodule

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;
  logic       clk, rst_n, cpol, cpha, lsb_first, host_sel, host_wr, host_rd, miso;
  logic [2:0] baud;
  logic [7:0] host_wdata, host_rdata;
  logic       irq, sck, mosi, ss_n;

  int total, bad, cyc;
  // reference model state
  bit  act, done_m, wcol_m, ie_m, arm_m;
  int  p;
  logic [7:0] tx_m, slave_byte;
  int  sedges;
  logic sck_prev;

  spi_xfer_master i_spi_xfer_master (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first),
    .baud(baud), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural slave: counts SCK edges while selected
  always @(sck or ss_n) begin
    if (ss_n) sedges = 0;
    else if (sck !== sck_prev) sedges = sedges + 1;
    sck_prev = sck;
  end

  always_comb begin
    int q;
    if (cpha) q = (sedges <= 1) ? 0 : (sedges - 1) / 2;
    else      q = sedges / 2;
    if (q > 7) q = 7;
    miso = lsb_first ? slave_byte[q] : slave_byte[7 - q];
  end

  task automatic check(string req, int actv, int expv);
    total++;
    if (actv != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, actv, expv, cyc);
    end
  endtask

  function automatic int half();
    return 1 << (baud + 1);
  endfunction

  task automatic step();
    int h, edges, s;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    h = half();
    if (act) begin
      p++;
      if (p == 18 * h) begin
        act = 0;
        done_m = 1;
      end
    end
    if (act) begin
      edges = p / h;
      if (edges > 16) edges = 16;
      check("R1/R5/R6 ss_n", ss_n, (p < 17 * h) ? 0 : 1);
      check("R2/R7 sck", sck, cpol ^ edges[0]);
      if (edges < 16) begin
        if (cpha) s = (edges <= 1) ? 0 : (edges - 1) / 2;
        else      s = edges / 2;
        check("R3 mosi", mosi, lsb_first ? tx_m[s] : tx_m[7 - s]);
      end
    end else begin
      check("R2 idle ss_n", ss_n, 1);
      check("R2 idle sck", sck, cpol);
    end
    check("R8 irq", irq, done_m & ie_m);
  endtask

  task automatic host_write(bit sel, logic [7:0] d);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    if (sel) begin
      if (arm_m) begin done_m = 0; wcol_m = 0; arm_m = 0; end
      if (act) wcol_m = 1;
      else begin act = 1; p = -1; tx_m = d; end
    end else ie_m = d[0];
    step();
    host_wr = 1'b0;
  endtask

  task automatic host_read(bit sel, output logic [7:0] v);
    host_sel = sel; host_rd = 1'b1;
    #1 v = host_rdata;
    if (sel) begin
      if (arm_m) begin done_m = 0; wcol_m = 0; arm_m = 0; end
    end else if (done_m || wcol_m) arm_m = 1;
    step();
    host_rd = 1'b0;
  endtask

  function automatic int stat_exp();
    return {done_m, wcol_m, 5'b0, ie_m};
  endfunction

  task automatic check_status(string req);
    logic [7:0] v;
    int e;
    e = stat_exp();
    host_read(0, v);
    check(req, v, e);
  endtask

  task automatic run_xfer(logic [7:0] tx, logic [7:0] sb);
    logic [7:0] v;
    slave_byte = sb;
    host_write(1, tx);
    while (act) step();
    check_status("R6 done flag set");
    host_read(1, v);
    check("R4 received byte", v, sb);
    check_status("R9 flags cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    total = 0; bad = 0; cyc = 0;
    act = 0; done_m = 0; wcol_m = 0; ie_m = 0; arm_m = 0; p = 0;
    tx_m = 8'h00; slave_byte = 8'h00; sedges = 0; sck_prev = 1'b0;
    cpol = 0; cpha = 0; lsb_first = 0; baud = 3'd0;
    host_sel = 0; host_wr = 0; host_rd = 0; host_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R11 reset state
    check("R11 ss_n", ss_n, 1);
    check("R11 sck", sck, 0);
    check("R11 irq", irq, 0);
    check_status("R11 status");

    host_write(0, 8'h01);
    // all modes and both bit orders (R2 R3 R4 R7)
    for (int m = 0; m < 4; m++) begin
      for (int lb = 0; lb < 2; lb++) begin
        cpol = m[1]; cpha = m[0]; lsb_first = lb[0];
        baud = 3'((m + lb) % 3);
        step();
        run_xfer(8'hA5 ^ 8'(m * 16 + lb), 8'h3C + 8'(m * 7 + lb * 33));
      end
    end

    // R8: flag with enable off keeps irq low, enabling raises it
    cpol = 0; cpha = 1; lsb_first = 0; baud = 3'd1;
    host_write(0, 8'h00);
    slave_byte = 8'h96;
    host_write(1, 8'h5A);
    while (act) step();
    check("R8 irq masked", irq, 0);
    host_write(0, 8'h01);
    check("R8 irq enabled", irq, 1);

    // R9: data read without prior status read keeps flags
    host_read(1, v);
    check("R9 no clear without status read", host_rdata, 8'h96);
    check_status("R9 flag still set");
    host_read(1, v);
    check_status("R9 cleared after sequence");

    // R10: collision mid-transfer
    cpol = 1; cpha = 0; lsb_first = 1; baud = 3'd1;
    slave_byte = 8'hC3;
    host_write(1, 8'h81);
    repeat (5 * half()) step();
    host_write(1, 8'h7E);
    check_status("R10 collision flag");
    while (act) step();
    host_read(1, v);
    check("R10 transfer unaffected", v, 8'hC3);
    check_status("R10 both flags");
    host_read(1, v);
    check_status("R10 flags cleared");

    // R6 back-to-back: write right after completion is accepted
    run_xfer(8'h12, 8'h34);
    run_xfer(8'hED, 8'hCB);

    // R7 slowest rate
    cpol = 0; cpha = 1; lsb_first = 1; baud = 3'd7;
    step();
    run_xfer(8'h69, 8'h0F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule